// File: doc/BRIEF.md
# Stepped Power-of-Two Clock Post-Divider

This block sits after a fast oscillator and turns its clock into the delivered output clock by dividing it by a power of two. A two-bit select code picks the base ratio. A power-down request multiplies that ratio by sixteen. The change is not made in one jump: the ratio doubles once per step, over four steps. Releasing the request halves it back over four steps. The request is sampled in a separate reference clock domain, and the step position is carried into the fast domain in Gray code.

Each ratio change and each output-enable change waits for the boundary at the end of an output high phase, so the output never shows a shortened pulse. Divide-by-one passes the fast clock through a gate that is updated on the falling edge. The block drives the output clock, its complement and the ratio currently in force.

Top module: `stepped_postdiv`

## Requirements
- R1: After the ratio has settled with `pd_i` low, `ratio_o` holds the division ratio as a plain binary number. Select code 0 gives 2, code 1 gives 4, code 2 gives 8 and code 3 gives 1. The period of `fout` equals that many `clk_vco` periods.
- R2: After the ratio has settled with `pd_i` high, the ratio is sixteen times the R1 value for the same code: 32, 64, 128 and 16 for codes 0 to 3. The `fout` period matches.
- R3: When `pd_i` rises, `ratio_o` takes exactly four new values, each twice the one before. When `pd_i` falls, it takes exactly four new values, each half the one before. The internal step count never exceeds four.
- R4: `pd_i` is sampled in the `clk_ref` domain, and one step is taken every STEP_CYC `clk_ref` cycles (default 4). With code 3, the final ratio of 16 is not reached within 13 `clk_ref` cycles of the request and has been reached by 30.
- R5: The ratio changes only at the end of an output high phase. No high or low phase of `fout` is shorter than half a `clk_vco` period, whatever the inputs do.
- R6: While the enable is off, `fout` stays low and `fout_n` stays high. This holds in the divide-by-one setting too.
- R7: `oe_i` is resynchronised and acts only at an output period boundary. Toggling it causes no short pulse, and the period is correct again after the output is re-enabled.
- R8: `fout_n` is always the complement of `fout`.
- R9: While `rst` is high, `ratio_o` reads 2, `fout` is low and `fout_n` is high.
- R10: A new select code takes effect at the next output period boundary. From ratio 8, changing the code to 0 leaves `ratio_o` unchanged one `clk_vco` cycle later and shows 2 within 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast source clock to be divided |
| clk_ref | input | 1 | Reference clock that paces the power-down steps |
| rst | input | 1 | Synchronous active-high reset for both domains |
| sel_i | input | 2 | Divide select code |
| pd_i | input | 1 | Power-down request (asynchronous) |
| oe_i | input | 1 | Output enable (asynchronous) |
| fout | output | 1 | Divided output clock |
| fout_n | output | 1 | Complement of the output clock |
| ratio_o | output | 8 | Division ratio in force, binary |

## Verification
The bench logs every value `ratio_o` takes during a power-down ramp. A design that jumped straight to the final ratio, or took a wrong number of steps, logs a sequence that is too short or does not double at each entry. A continuous pulse-width monitor on `fout` catches updates made mid-period, and enable or mode switches made on the wrong edge. Any of these leaves a phase narrower than half a fast-clock period. Timed samples around the ramp and around a select change expose a design that ignores the reference-domain pacing, or that applies a new code before the synchroniser and the period boundary allow.

// File: rtl/psd_pkg.sv
package psd_pkg;

  localparam int SEL_W = 2;

  function automatic logic [7:0] bin2gray(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [7:0] gray2bin(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // log2 of the base ratio for each select code
  function automatic logic [2:0] base_exp(input logic [SEL_W-1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd3;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/psd_sync.sv
module psd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/psd_stepper.sv
module psd_stepper
  import psd_pkg::*;
#(
  parameter int STEPS    = 4,
  parameter int STEP_CYC = 4,
  parameter int STEP_W   = 3
) (
  input  logic              clk_ref,
  input  logic              rst,
  input  logic              pd_req,
  output logic [STEP_W-1:0] step_gray_o
);

  localparam int TK_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic              pd_s;
  logic [TK_W-1:0]   tk_q;
  logic              tick;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] gray_q;

  psd_sync #(.W(1), .STAGES(2)) u_pd_sync (
    .clk(clk_ref), .rst(rst), .d(pd_req), .q(pd_s)
  );

  assign tick = (tk_q == TK_W'(STEP_CYC - 1));

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      tk_q   <= '0;
      step_q <= '0;
      gray_q <= '0;
    end else begin
      tk_q <= tick ? '0 : tk_q + 1'b1;
      if (tick && pd_s && step_q != STEP_W'(STEPS))
        step_q <= step_q + 1'b1;
      else if (tick && !pd_s && step_q != '0)
        step_q <= step_q - 1'b1;
      gray_q <= STEP_W'(bin2gray(8'(step_q)));
    end
  end

  assign step_gray_o = gray_q;

endmodule

// File: rtl/psd_divcore.sv
module psd_divcore #(
  parameter int EXP_W   = 3,
  parameter int RATIO_W = 8
) (
  input  logic               clk_vco,
  input  logic               rst,
  input  logic [EXP_W-1:0]   exp_tgt,
  input  logic               en_tgt,
  output logic               fout,
  output logic [RATIO_W-1:0] ratio_o
);

  logic [EXP_W-1:0]   e_q;
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] r_cur;
  logic [RATIO_W-1:0] cnt_nx;
  logic               div_q;
  logic               en_q;
  logic               wrap;
  logic               mode_n;
  logic               gate_n;

  assign r_cur  = RATIO_W'(1) << e_q;
  assign cnt_nx = cnt_q + 1'b1;
  assign wrap   = (e_q == '0) || (cnt_q == r_cur - 1'b1);

  // Period counter: low half first, high half second, updates at wrap
  always_ff @(posedge clk_vco) begin
    if (rst) begin
      e_q     <= EXP_W'(1);
      cnt_q   <= '0;
      div_q   <= 1'b0;
      en_q    <= 1'b0;
      ratio_q <= RATIO_W'(2);
    end else if (wrap) begin
      e_q     <= exp_tgt;
      en_q    <= en_tgt;
      cnt_q   <= '0;
      div_q   <= 1'b0;
      ratio_q <= RATIO_W'(1) << exp_tgt;
    end else begin
      cnt_q <= cnt_nx;
      div_q <= (cnt_nx >= (r_cur >> 1));
    end
  end

  // Bypass selection and gate change only while clk_vco is low
  always_ff @(negedge clk_vco) begin
    if (rst) begin
      mode_n <= 1'b0;
      gate_n <= 1'b0;
    end else begin
      mode_n <= (e_q == '0);
      gate_n <= en_q;
    end
  end

  assign fout    = mode_n ? (clk_vco & gate_n) : (div_q & en_q);
  assign ratio_o = ratio_q;

endmodule

// File: rtl/stepped_postdiv.sv
module stepped_postdiv
  import psd_pkg::*;
#(
  parameter int STEPS    = 4,
  parameter int STEP_CYC = 4
) (
  input  logic             clk_vco,
  input  logic             clk_ref,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pd_i,
  input  logic             oe_i,
  output logic             fout,
  output logic             fout_n,
  output logic [3+STEPS:0] ratio_o
);

  localparam int MAX_EXP = 3 + STEPS;
  localparam int EXP_W   = $clog2(MAX_EXP + 1);
  localparam int RATIO_W = MAX_EXP + 1;
  localparam int STEP_W  = $clog2(STEPS + 1);

  logic [STEP_W-1:0] step_g;
  logic [STEP_W-1:0] step_g_s;
  logic [STEP_W-1:0] step_b;
  logic [SEL_W-1:0]  sel_s;
  logic              oe_s;
  logic [EXP_W-1:0]  exp_tgt;

  psd_stepper #(.STEPS(STEPS), .STEP_CYC(STEP_CYC), .STEP_W(STEP_W)) u_stepper (
    .clk_ref(clk_ref), .rst(rst), .pd_req(pd_i), .step_gray_o(step_g)
  );

  psd_sync #(.W(STEP_W), .STAGES(2)) u_step_sync (
    .clk(clk_vco), .rst(rst), .d(step_g), .q(step_g_s)
  );

  psd_sync #(.W(SEL_W), .STAGES(2)) u_sel_sync (
    .clk(clk_vco), .rst(rst), .d(sel_i), .q(sel_s)
  );

  psd_sync #(.W(1), .STAGES(2)) u_oe_sync (
    .clk(clk_vco), .rst(rst), .d(oe_i), .q(oe_s)
  );

  assign step_b  = STEP_W'(gray2bin(8'(step_g_s)));
  assign exp_tgt = EXP_W'(base_exp(sel_s)) + EXP_W'(step_b);

  psd_divcore #(.EXP_W(EXP_W), .RATIO_W(RATIO_W)) u_core (
    .clk_vco(clk_vco), .rst(rst), .exp_tgt(exp_tgt), .en_tgt(oe_s),
    .fout(fout), .ratio_o(ratio_o)
  );

  assign fout_n = ~fout;

endmodule

// File: rtl/stepped_postdiv_chk.sv
module psd_divcore_chk #(
  parameter int RATIO_W = 8
) (
  input logic               clk_vco,
  input logic               rst,
  input logic [RATIO_W-1:0] ratio_q,
  input logic [RATIO_W-1:0] cnt_q,
  input logic               div_q,
  input logic               en_q
);

  assert_ratio_pow2_R1: assert property (@(posedge clk_vco) disable iff (rst)
    $countones(ratio_q) == 1);

  assert_ratio_at_boundary_R5: assert property (@(posedge clk_vco) disable iff (rst)
    !$stable(ratio_q) |-> cnt_q == '0);

  assert_high_phase_half_R5: assert property (@(posedge clk_vco) disable iff (rst)
    $rose(div_q) |-> cnt_q == (ratio_q >> 1));

  assert_enable_at_boundary_R7: assert property (@(posedge clk_vco) disable iff (rst)
    !$stable(en_q) |-> cnt_q == '0);

endmodule

module psd_stepper_chk #(
  parameter int STEP_W = 3,
  parameter int STEPS  = 4
) (
  input logic              clk_ref,
  input logic              rst,
  input logic [STEP_W-1:0] step_q,
  input logic              pd_s
);

  assert_step_unit_R3: assert property (@(posedge clk_ref) disable iff (rst)
    !$stable(step_q) |->
      (step_q == STEP_W'($past(step_q) + 1'b1)) || (STEP_W'(step_q + 1'b1) == $past(step_q)));

  assert_step_limit_R3: assert property (@(posedge clk_ref) disable iff (rst)
    step_q <= STEP_W'(STEPS));

  assert_step_up_pd_R4: assert property (@(posedge clk_ref) disable iff (rst)
    (step_q > $past(step_q)) |-> $past(pd_s));

  assert_step_down_pd_R4: assert property (@(posedge clk_ref) disable iff (rst)
    (step_q < $past(step_q)) |-> !$past(pd_s));

endmodule

bind psd_divcore psd_divcore_chk #(.RATIO_W(RATIO_W)) u_divcore_chk (
  .clk_vco(clk_vco), .rst(rst), .ratio_q(ratio_q), .cnt_q(cnt_q),
  .div_q(div_q), .en_q(en_q)
);

bind psd_stepper psd_stepper_chk #(.STEP_W(STEP_W), .STEPS(STEPS)) u_stepper_chk (
  .clk_ref(clk_ref), .rst(rst), .step_q(step_q), .pd_s(pd_s)
);

// File: tb/test_stepped_postdiv.sv
`timescale 1ns/1ps
module test_stepped_postdiv;

  localparam int VCO_T  = 4;
  localparam int REF_T  = 20;
  localparam int WDOG_T = 400000;

  // entry: {sel[1:0], pd, expected ratio[7:0]}
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 1'b0, 8'd2},   {2'd1, 1'b0, 8'd4},
    {2'd2, 1'b0, 8'd8},   {2'd3, 1'b0, 8'd1},
    {2'd0, 1'b1, 8'd32},  {2'd1, 1'b1, 8'd64},
    {2'd2, 1'b1, 8'd128}, {2'd3, 1'b1, 8'd16}
  };

  logic       clk_vco = 1'b0;
  logic       clk_ref = 1'b0;
  logic       rst     = 1'b1;
  logic [1:0] sel     = 2'd0;
  logic       pd      = 1'b0;
  logic       oe      = 1'b1;
  logic       fout;
  logic       fout_n;
  logic [7:0] ratio_o;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  stepped_postdiv i_stepped_postdiv (
    .clk_vco(clk_vco), .clk_ref(clk_ref), .rst(rst), .sel_i(sel), .pd_i(pd),
    .oe_i(oe), .fout(fout), .fout_n(fout_n), .ratio_o(ratio_o)
  );

  always #(VCO_T/2) clk_vco = ~clk_vco;
  always #(REF_T/2) clk_ref = ~clk_ref;

  // ratio value log
  bit log_on = 1'b0;
  int log_n  = 0;
  int log_v [8];
  int last_r = 0;
  always @(negedge clk_vco) begin
    if (!log_on) log_n = 0;
    else if (int'(ratio_o) != last_r && log_n < 8) begin
      log_v[log_n] = int'(ratio_o);
      log_n++;
    end
    last_r = int'(ratio_o);
  end

  // pulse width monitor
  bit      mon_on = 1'b0;
  int      runt_n = 0;
  realtime last_t = -1.0;
  always @(fout) begin
    if (mon_on) begin
      if (last_t >= 0.0 && ($realtime - last_t) < (VCO_T / 2.0 - 0.01)) runt_n++;
      last_t = $realtime;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic meas(output int per);
    realtime t0;
    @(posedge fout);
    t0 = $realtime;
    @(posedge fout);
    per = int'(($realtime - t0) / VCO_T);
  endtask

  task automatic settle();
    repeat (60) @(negedge clk_ref);
    @(negedge clk_vco);
  endtask

  initial begin
    #(WDOG_T);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int per;
    int exp_r;
    // R9: reset state
    repeat (10) @(negedge clk_ref);
    @(negedge clk_vco);
    chk(ratio_o == 8'd2, "R9 ratio", int'(ratio_o), 2);
    chk(fout == 1'b0 && fout_n == 1'b1, "R9 outputs", int'({fout, fout_n}), 1);
    @(negedge clk_ref);
    rst = 1'b0;
    mon_on = 1'b1;

    // R1/R2 table walk
    for (int i = 0; i < 8; i++) begin
      sel   = VEC[i][10:9];
      pd    = VEC[i][8];
      exp_r = int'(VEC[i][7:0]);
      settle();
      chk(int'(ratio_o) == exp_r, pd ? "R2 ratio" : "R1 ratio", int'(ratio_o), exp_r);
      meas(per);
      meas(per);
      chk(per == exp_r, pd ? "R2 period" : "R1 period", per, exp_r);
      @(negedge clk_vco);
      chk(fout_n == ~fout, "R8 complement", int'(fout_n), int'(~fout));
    end

    // R3: ramp up and down from ratio 2
    sel = 2'd0; pd = 1'b0;
    settle();
    log_on = 1'b1;
    pd = 1'b1;
    settle();
    chk(log_n == 4, "R3 up count", log_n, 4);
    for (int k = 0; k < 4; k++)
      chk(log_v[k] == (4 << k), "R3 up value", log_v[k], 4 << k);
    log_on = 1'b0;
    @(negedge clk_vco);
    log_on = 1'b1;
    pd = 1'b0;
    settle();
    chk(log_n == 4, "R3 down count", log_n, 4);
    for (int k = 0; k < 4; k++)
      chk(log_v[k] == (16 >> k), "R3 down value", log_v[k], 16 >> k);
    log_on = 1'b0;

    // R4: pacing by the reference clock
    sel = 2'd3;
    settle();
    @(negedge clk_ref);
    pd = 1'b1;
    repeat (13) @(negedge clk_ref);
    chk(ratio_o != 8'd16, "R4 not early", int'(ratio_o), 0);
    repeat (17) @(negedge clk_ref);
    chk(ratio_o == 8'd16, "R4 reached", int'(ratio_o), 16);

    // R10: select change latency
    pd = 1'b0; sel = 2'd2;
    settle();
    sel = 2'd0;
    @(negedge clk_vco);
    chk(ratio_o == 8'd8, "R10 not early", int'(ratio_o), 8);
    repeat (15) @(negedge clk_vco);
    chk(ratio_o == 8'd2, "R10 applied", int'(ratio_o), 2);

    // R6: enable off holds output
    sel = 2'd1;
    settle();
    oe = 1'b0;
    repeat (40) @(negedge clk_vco);
    for (int j = 0; j < 6; j++) begin
      #3;
      chk(fout == 1'b0 && fout_n == 1'b1, "R6 held divided", int'({fout, fout_n}), 1);
    end
    sel = 2'd3;
    settle();
    for (int j = 0; j < 6; j++) begin
      #1;
      chk(fout == 1'b0 && fout_n == 1'b1, "R6 held bypass", int'({fout, fout_n}), 1);
    end

    // R7: re-enable and toggling stress
    oe = 1'b1;
    repeat (20) @(negedge clk_vco);
    meas(per);
    chk(per == 1, "R7 bypass period", per, 1);
    for (int k = 0; k < 40; k++) begin
      oe  = ~oe;
      sel = 2'(k);
      pd  = k[3];
      #(37 + 11 * k);
    end
    oe = 1'b1; pd = 1'b0; sel = 2'd1;
    settle();
    meas(per);
    chk(per == 4, "R7 period after toggling", per, 4);
    chk(runt_n == 0, "R5 R7 no short pulse", runt_n, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule